// File: doc/BRIEF.md
# Prioritised Interrupt Vector Register

This block reports pending bus controller events as one small number rather than as a bitmap of status flags. Five event sources feed it as single-cycle pulses. Each pulse sets a sticky pending bit. A read of the vector register returns the code of the most urgent pending event and clears only that event. Software reads the register repeatedly until it returns zero, handling one source per read.

An interrupt output stays high while any event is pending. It can be used directly as a level interrupt. Reads at any other register address return zero and leave the pending events unchanged.

Top module: `ivr_vector_reg`

## Requirements
- R1: After reset no event is pending, `irq` is low and `rd_data` is zero.
- R2: Source bit i of `evt_pulse` maps to code i+1. Bit 0 is arbitration lost (code 1), bit 1 is no-acknowledge (code 2), bit 2 is access ready (code 3), bit 3 is receive ready (code 4) and bit 4 is transmit ready (code 5). Code 0 means nothing is pending.
- R3: When several events are pending, a read reports the lowest nonzero code among them.
- R4: A read strobe with `rd_addr` equal to 0x0C loads the reported code into `rd_data` at that clock edge. The value is visible in the following cycle, and the same edge clears the reported event's pending bit.
- R5: A read strobe at any other address drives `rd_data` to zero and leaves every pending bit unchanged.
- R6: An event pulse arriving in the same cycle as a vector read is kept pending. This also holds when the pulse is for the source being cleared.
- R7: `irq` rises in the cycle after any event pulse and stays high until every pending bit has been reported.
- R8: Codes 6 and 7 never appear, and bits 15 to 3 of `rd_data` are always zero.
- R9: A vector read when nothing is pending returns zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 5 | Event pulses, one bit per source |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register byte offset of the read |
| rd_data | output | 16 | Read data, registered |
| irq | output | 1 | High while any event is pending |

## Verification
Every result arrives exactly one cycle after its cause. A pulse on the clock edge sets a pending bit, and `irq` follows from that bit in the next cycle. A read strobe sampled at an edge places its code in `rd_data` and clears the bit on that same edge. The bench drives inputs just after a rising edge. It samples the outputs just after the next rising edge, so each check lands in the first cycle where the result is due. No check ever waits on a range of cycles.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

  typedef enum logic [2:0] {
    VEC_NONE     = 3'd0,
    VEC_ARB_LOST = 3'd1,
    VEC_NACK     = 3'd2,
    VEC_ACC_RDY  = 3'd3,
    VEC_RX_RDY   = 3'd4,
    VEC_TX_RDY   = 3'd5
  } vec_code_e;

  // code reported for source index idx
  function automatic int unsigned code_of_index(input int unsigned idx);
    return idx + 1;
  endfunction

endpackage

// File: rtl/ivr_pending.sv
module ivr_pending #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  // a set in the same cycle as a clear wins, so no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/ivr_prio_enc.sv
module ivr_prio_enc #(
  parameter int NUM_SRC = 5,
  parameter int CODE_W  = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [CODE_W-1:0]  code_o
);
  import ivr_pkg::*;

  logic [NUM_SRC:0] below;
  assign below[0] = 1'b0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign grant_o[i]  = req_i[i] & ~below[i];
    assign below[i+1]  = below[i] | req_i[i];
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (grant_o[i]) code_o = code_o | CODE_W'(code_of_index(i));
  end
endmodule

// File: rtl/ivr_vector_reg.sv
module ivr_vector_reg #(
  parameter int          NUM_SRC    = 5,
  parameter int          DATA_W     = 16,
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  VEC_OFFSET = 8'h0C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic               rd_stb,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq
);
  localparam int CODE_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] clr_mask;
  logic [CODE_W-1:0]  code;
  logic               rd_hit;

  assign rd_hit   = rd_stb && (rd_addr == ADDR_W'(VEC_OFFSET));
  assign clr_mask = rd_hit ? grant : '0;

  ivr_pending #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_pulse),
    .clr_i  (clr_mask),
    .pend_o (pend)
  );

  ivr_prio_enc #(.NUM_SRC(NUM_SRC), .CODE_W(CODE_W)) u_enc (
    .req_i   (pend),
    .grant_o (grant),
    .code_o  (code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_hit) rd_data <= DATA_W'(code);
    else if (rd_stb) rd_data <= '0;
  end

  assign irq = |pend;
endmodule

// File: rtl/ivr_vector_reg_chk.sv
module ivr_vector_reg_chk #(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_pulse,
  input logic               rd_stb,
  input logic               rd_hit,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] clr_mask,
  input logic [DATA_W-1:0]  rd_data,
  input logic               irq
);
  p_irq_after_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> irq);

  p_code_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data <= DATA_W'(NUM_SRC)));

  p_single_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_mask));

  p_clear_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && ((clr_mask & evt_pulse) == '0)) |=> ((pend & $past(clr_mask)) == '0));

  p_no_loss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((pend & $past(evt_pulse)) == $past(evt_pulse)));

  p_other_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_hit && evt_pulse == '0) |=> ($stable(pend) && rd_data == '0));
endmodule

bind ivr_vector_reg ivr_vector_reg_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_pulse (evt_pulse),
  .rd_stb    (rd_stb),
  .rd_hit    (rd_hit),
  .pend      (pend),
  .clr_mask  (clr_mask),
  .rd_data   (rd_data),
  .irq       (irq)
);

// File: tb/test_ivr_vector_reg.sv
module test_ivr_vector_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  evt_pulse = '0;
  logic        rd_stb = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ivr_vector_reg i_ivr_vector_reg (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // lowest set bit index plus one, zero if none
  function automatic int lowest_code(input int m);
    for (int b = 0; b < 5; b++) if (m[b]) return b + 1;
    return 0;
  endfunction

  task automatic rd(input logic [7:0] a, input logic [4:0] ev);
    rd_stb = 1'b1; rd_addr = a; evt_pulse = ev;
    tick();
    rd_stb = 1'b0; evt_pulse = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int rem;
    int e;
    repeat (3) tick();
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    tick();
    // R9 empty read
    rd(8'h0C, 5'd0);
    chk("R9 empty read", rd_data, 0);
    chk("R9 irq stays low", irq, 0);

    // R2 R3 R4 R7 R8 exhaustive over every pending pattern
    for (int p = 0; p < 32; p++) begin
      evt_pulse = 5'(p);
      tick();
      evt_pulse = '0;
      chk("R7 irq after pulses", irq, (p != 0) ? 1 : 0);
      rem = p;
      for (int k = 0; k < 6; k++) begin
        e = lowest_code(rem);
        rd(8'h0C, 5'd0);
        chk("R3 R4 R8 vector code", rd_data, e);
        if (e != 0) rem = rem & ~(1 << (e - 1));
        chk("R7 irq while pending", irq, (rem != 0) ? 1 : 0);
      end
    end

    // R2 named code mapping for each source alone
    for (int s = 0; s < 5; s++) begin
      evt_pulse = 5'(1 << s);
      tick();
      evt_pulse = '0;
      rd(8'h0C, 5'd0);
      chk("R2 source code", rd_data, s + 1);
    end

    // R5 read at another address
    evt_pulse = 5'b10000;
    tick();
    evt_pulse = '0;
    rd(8'h0C, 5'd0);
    chk("R4 code before", rd_data, 5);
    evt_pulse = 5'b10000;
    tick();
    evt_pulse = '0;
    rd(8'h08, 5'd0);
    chk("R5 other address data", rd_data, 0);
    chk("R5 irq kept", irq, 1);
    rd(8'h0D, 5'd0);
    chk("R5 other address data 2", rd_data, 0);
    rd(8'h0C, 5'd0);
    chk("R5 pending kept", rd_data, 5);
    chk("R5 irq cleared", irq, 0);

    // R6 different source arrives during read
    evt_pulse = 5'b00001;
    tick();
    rd(8'h0C, 5'b00010);
    chk("R6 first code", rd_data, 1);
    chk("R6 irq", irq, 1);
    rd(8'h0C, 5'd0);
    chk("R6 late source kept", rd_data, 2);
    chk("R6 irq drained", irq, 0);

    // R6 same source re-arrives during its own read
    evt_pulse = 5'b00001;
    tick();
    rd(8'h0C, 5'b00001);
    chk("R6 same first", rd_data, 1);
    chk("R6 same irq", irq, 1);
    rd(8'h0C, 5'd0);
    chk("R6 same kept", rd_data, 1);
    rd(8'h0C, 5'd0);
    chk("R9 drained", rd_data, 0);

    finish_run();
  end
endmodule